// File: doc/BRIEF.md
# Condition-Gated Integer ALU with Status Flags

This block performs one integer data-processing operation per clock cycle and keeps four status flags: negative, zero, carry and overflow. Each cycle it receives an operation code, a condition field, a set-flags bit, a first operand, a second operand that an upstream shifter has already prepared, and that shifter's carry-out. It tests the condition against the flags it holds. From that test it decides whether the operation takes effect.

When the condition passes, the block drives the computed value and a destination write strobe. It also presents the flag values that the register will load at the next clock edge. When the condition fails, no write happens and the flags keep their value. Compare and test operations only update flags. Every other operation updates flags only when asked to. This lets software use conditional execution in place of short forward branches.

Top module: `cc_alu`

## Requirements
- R1: Arithmetic opcodes give these results on `alu_res_o`, where C is the held carry flag: 0100 A+B, 0101 A+B+C, 0010 A−B, 0110 A−B+C−1, 0011 B−A, 0111 B−A+C−1, all modulo 2^32.
- R2: Logical and move opcodes give these results: 0000 A AND B, 1100 A OR B, 0001 A XOR B, 1110 A AND NOT B, 1101 B, 1111 NOT B.
- R3: The flag-only opcodes are 1010 compare (A−B), 1011 compare-negated (A+B), 1000 test (A AND B) and 1001 test-equivalence (A XOR B). They never raise `dst_we_o`, and when executed they always update the flags, whatever `set_flags_i` is.
- R4: All other opcodes raise `dst_we_o` when executed. They update the flags only when `set_flags_i` is 1. Otherwise `flags_nxt_o` equals the held flags.
- R5: On a flag update, N (bit 3 of `flags_nxt_o`) equals bit 31 of the result. Z (bit 2) is 1 exactly when the 32-bit result is zero.
- R6: On a flag update by an arithmetic or compare opcode, C (bit 1) is the adder's carry-out. For subtraction forms, C=1 means no borrow occurred.
- R7: On a flag update by a logical, move or test opcode, C takes `shift_carry_i` and V (bit 0) keeps its held value.
- R8: On a flag update by an arithmetic or compare opcode, V is 1 exactly when the signed result overflows 32 bits.
- R9: Condition codes 0000..1110 are EQ Z, NE !Z, HS C, LO !C, MI N, PL !N, VS V, VC !V, HI C&!Z, LS !C|Z, GE N==V, LT N!=V, GT !Z&(N==V), LE Z|(N!=V), AL always.
- R10: When the condition fails, and always for condition 1111, `dst_we_o` is 0 and `flags_nxt_o` equals the held flags.
- R11: The flag register resets to 0000 on a synchronous active-low reset. At each clock edge it loads `flags_nxt_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| opcode_i | input | 4 | Operation selector |
| cond_i | input | 4 | Condition field tested against held flags |
| set_flags_i | input | 1 | Request a flag update for non-flag-only operations |
| opnd_a_i | input | 32 | First operand |
| opnd_b_i | input | 32 | Second operand, already shifted |
| shift_carry_i | input | 1 | Carry-out of the upstream shifter |
| alu_res_o | output | 32 | Computed value |
| dst_we_o | output | 1 | Destination register write strobe |
| flags_nxt_o | output | 4 | Flag values loaded at next edge {N,Z,C,V} |

## Verification
The checker watches several behaviours on every cycle. A never-condition or a flag-only opcode must not raise the write strobe. Flags must hold when no update is requested. The register must load the presented next value. On executed updates, N and Z must track the result, and logical updates must take C from the shifter and keep V. The arithmetic values, carry and overflow for all six arithmetic forms, and each of the fifteen condition tests against real flag states, can only be confirmed by the bench's reference model. The bench drives directed boundary operands and long random sequences through that model.

// File: rtl/cc_alu_pkg.sv
// Shared opcode and condition encodings for the condition-gated ALU.
package cc_alu_pkg;
    typedef enum logic [3:0] {
        OP_AND = 4'h0, OP_EOR = 4'h1, OP_SUB = 4'h2, OP_RSB = 4'h3,
        OP_ADD = 4'h4, OP_ADC = 4'h5, OP_SBC = 4'h6, OP_RSC = 4'h7,
        OP_TST = 4'h8, OP_TEQ = 4'h9, OP_CMP = 4'hA, OP_CMN = 4'hB,
        OP_ORR = 4'hC, OP_MOV = 4'hD, OP_BIC = 4'hE, OP_MVN = 4'hF
    } alu_op_e;

    typedef enum logic [3:0] {
        CC_EQ = 4'h0, CC_NE = 4'h1, CC_HS = 4'h2, CC_LO = 4'h3,
        CC_MI = 4'h4, CC_PL = 4'h5, CC_VS = 4'h6, CC_VC = 4'h7,
        CC_HI = 4'h8, CC_LS = 4'h9, CC_GE = 4'hA, CC_LT = 4'hB,
        CC_GT = 4'hC, CC_LE = 4'hD, CC_AL = 4'hE, CC_NV = 4'hF
    } cond_e;

    // Flag vector layout: N at 3, Z at 2, C at 1, V at 0.
    localparam int FLAG_N = 3;
    localparam int FLAG_Z = 2;
    localparam int FLAG_C = 1;
    localparam int FLAG_V = 0;
endpackage

// File: rtl/cc_alu_cond.sv
// Condition evaluator: decides from the held flags whether an operation
// executes. Assumes flags are laid out as in cc_alu_pkg.
module cc_alu_cond
    import cc_alu_pkg::*;
(
    input  logic [3:0] cond_i,
    input  logic [3:0] flags_i,
    output logic       pass_o
);
    logic n, z, c, v;
    assign n = flags_i[FLAG_N];
    assign z = flags_i[FLAG_Z];
    assign c = flags_i[FLAG_C];
    assign v = flags_i[FLAG_V];

    // Select the flag test named by the condition field.
    always_comb begin
        unique case (cond_e'(cond_i))
            CC_EQ:   pass_o = z;
            CC_NE:   pass_o = !z;
            CC_HS:   pass_o = c;
            CC_LO:   pass_o = !c;
            CC_MI:   pass_o = n;
            CC_PL:   pass_o = !n;
            CC_VS:   pass_o = v;
            CC_VC:   pass_o = !v;
            CC_HI:   pass_o = c && !z;
            CC_LS:   pass_o = !c || z;
            CC_GE:   pass_o = (n == v);
            CC_LT:   pass_o = (n != v);
            CC_GT:   pass_o = !z && (n == v);
            CC_LE:   pass_o = z || (n != v);
            CC_AL:   pass_o = 1'b1;
            default: pass_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/cc_alu_core.sv
// Datapath: one shared adder for all arithmetic and compare forms, plus a
// logic unit. Subtraction is done as x + ~y + carry-in, so carry-out 1 means
// no borrow. Assumes operand B is already shifted upstream.
module cc_alu_core
    import cc_alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [3:0]       op_i,
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             carry_flag_i,
    output logic [WIDTH-1:0] res_o,
    output logic             add_carry_o,
    output logic             add_ovf_o,
    output logic             is_arith_o,
    output logic             is_flag_only_o
);
    localparam int SUM_W = WIDTH + 1;

    logic [WIDTH-1:0] add_x, add_y, logic_res;
    logic             add_cin;
    logic [SUM_W-1:0] sum;

    // Choose adder operands and carry-in for each arithmetic form.
    always_comb begin
        add_x      = a_i;
        add_y      = b_i;
        add_cin    = 1'b0;
        is_arith_o = 1'b1;
        unique case (alu_op_e'(op_i))
            OP_ADD, OP_CMN: begin add_x = a_i;  add_y = b_i;  add_cin = 1'b0;         end
            OP_ADC:         begin add_x = a_i;  add_y = b_i;  add_cin = carry_flag_i; end
            OP_SUB, OP_CMP: begin add_x = a_i;  add_y = ~b_i; add_cin = 1'b1;         end
            OP_SBC:         begin add_x = a_i;  add_y = ~b_i; add_cin = carry_flag_i; end
            OP_RSB:         begin add_x = b_i;  add_y = ~a_i; add_cin = 1'b1;         end
            OP_RSC:         begin add_x = b_i;  add_y = ~a_i; add_cin = carry_flag_i; end
            default:        is_arith_o = 1'b0;
        endcase
    end

    assign sum         = {1'b0, add_x} + {1'b0, add_y} + {{WIDTH{1'b0}}, add_cin};
    assign add_carry_o = sum[WIDTH];
    assign add_ovf_o   = (add_x[WIDTH-1] == add_y[WIDTH-1]) &&
                         (sum[WIDTH-1] != add_x[WIDTH-1]);

    // Bitwise and move forms.
    always_comb begin
        unique case (alu_op_e'(op_i))
            OP_AND, OP_TST: logic_res = a_i & b_i;
            OP_EOR, OP_TEQ: logic_res = a_i ^ b_i;
            OP_ORR:         logic_res = a_i | b_i;
            OP_BIC:         logic_res = a_i & ~b_i;
            OP_MOV:         logic_res = b_i;
            OP_MVN:         logic_res = ~b_i;
            default:        logic_res = '0;
        endcase
    end

    assign is_flag_only_o = (op_i[3:2] == 2'b10);
    assign res_o          = is_arith_o ? sum[WIDTH-1:0] : logic_res;
endmodule

// File: rtl/cc_alu_flags.sv
// Flag unit: forms the next NZCV value and holds the flag register.
// Assumes update_i is already gated by the condition result.
module cc_alu_flags
    import cc_alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             update_i,
    input  logic             is_arith_i,
    input  logic [WIDTH-1:0] res_i,
    input  logic             add_carry_i,
    input  logic             add_ovf_i,
    input  logic             shift_carry_i,
    output logic [3:0]       flags_q_o,
    output logic [3:0]       flags_nxt_o
);
    logic [3:0] computed;

    // Build the candidate flag value from the result and operation class.
    always_comb begin
        computed[FLAG_N] = res_i[WIDTH-1];
        computed[FLAG_Z] = (res_i == '0);
        computed[FLAG_C] = is_arith_i ? add_carry_i : shift_carry_i;
        computed[FLAG_V] = is_arith_i ? add_ovf_i : flags_q_o[FLAG_V];
    end

    assign flags_nxt_o = update_i ? computed : flags_q_o;

    // Flag register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) flags_q_o <= 4'b0000;
        else        flags_q_o <= flags_nxt_o;
    end
endmodule

// File: rtl/cc_alu.sv
// Top level: condition-gated ALU with held NZCV flags. One operation per
// cycle; the result and write strobe are combinational from the inputs and
// held flags, and the flags register loads flags_nxt_o each edge.
module cc_alu
    import cc_alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [3:0]       opcode_i,
    input  logic [3:0]       cond_i,
    input  logic             set_flags_i,
    input  logic [WIDTH-1:0] opnd_a_i,
    input  logic [WIDTH-1:0] opnd_b_i,
    input  logic             shift_carry_i,
    output logic [WIDTH-1:0] alu_res_o,
    output logic             dst_we_o,
    output logic [3:0]       flags_nxt_o
);
    logic [3:0] flags_q;
    logic       cond_pass, add_carry, add_ovf, is_arith, is_flag_only, do_update;

    cc_alu_cond u_cond (
        .cond_i  (cond_i),
        .flags_i (flags_q),
        .pass_o  (cond_pass)
    );

    cc_alu_core #(.WIDTH(WIDTH)) u_core (
        .op_i           (opcode_i),
        .a_i            (opnd_a_i),
        .b_i            (opnd_b_i),
        .carry_flag_i   (flags_q[FLAG_C]),
        .res_o          (alu_res_o),
        .add_carry_o    (add_carry),
        .add_ovf_o      (add_ovf),
        .is_arith_o     (is_arith),
        .is_flag_only_o (is_flag_only)
    );

    assign dst_we_o  = cond_pass && !is_flag_only;
    assign do_update = cond_pass && (is_flag_only || set_flags_i);

    cc_alu_flags #(.WIDTH(WIDTH)) u_flags (
        .clk           (clk),
        .rst_n         (rst_n),
        .update_i      (do_update),
        .is_arith_i    (is_arith),
        .res_i         (alu_res_o),
        .add_carry_i   (add_carry),
        .add_ovf_i     (add_ovf),
        .shift_carry_i (shift_carry_i),
        .flags_q_o     (flags_q),
        .flags_nxt_o   (flags_nxt_o)
    );
endmodule

// File: rtl/cc_alu_chk.sv
// Checker for cc_alu: cycle-level properties over ports and the held flags.
module cc_alu_chk #(
    parameter int WIDTH = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic [3:0]       opcode_i,
    input logic [3:0]       cond_i,
    input logic             set_flags_i,
    input logic             shift_carry_i,
    input logic [WIDTH-1:0] alu_res_o,
    input logic             dst_we_o,
    input logic [3:0]       flags_nxt_o,
    input logic [3:0]       flags_q
);
    logic flag_only, logical, al_exec;
    assign flag_only = (opcode_i[3:2] == 2'b10);
    assign logical   = (opcode_i inside {4'h0, 4'h1, 4'h8, 4'h9, 4'hC, 4'hD, 4'hE, 4'hF});
    assign al_exec   = (cond_i == 4'hE);

    // R10: never-condition blocks write and flag change
    p_never_blocks_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_i == 4'hF) |-> (!dst_we_o && flags_nxt_o == flags_q));

    // R3: flag-only opcodes never write
    p_test_no_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        flag_only |-> !dst_we_o);

    // R4: no update request keeps flags
    p_hold_flags_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag_only && !set_flags_i) |-> (flags_nxt_o == flags_q));

    // R4: always-condition on a writing opcode writes
    p_al_writes_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (al_exec && !flag_only) |-> dst_we_o);

    // R11: register loads the presented next value
    p_reg_loads_r11: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (flags_q == $past(flags_nxt_o)));

    // R5: N and Z follow the result on an executed update
    p_nz_track_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (al_exec && (flag_only || set_flags_i)) |->
        (flags_nxt_o[3] == alu_res_o[WIDTH-1] && flags_nxt_o[2] == (alu_res_o == '0)));

    // R7: logical updates take shifter carry and keep V
    p_logic_cv_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (al_exec && logical && (flag_only || set_flags_i)) |->
        (flags_nxt_o[1] == shift_carry_i && flags_nxt_o[0] == flags_q[0]));
endmodule

bind cc_alu cc_alu_chk #(.WIDTH(WIDTH)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .opcode_i      (opcode_i),
    .cond_i        (cond_i),
    .set_flags_i   (set_flags_i),
    .shift_carry_i (shift_carry_i),
    .alu_res_o     (alu_res_o),
    .dst_we_o      (dst_we_o),
    .flags_nxt_o   (flags_nxt_o),
    .flags_q       (flags_q)
);

// File: tb/sim_cc_alu.sv
module sim_cc_alu;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  opcode_i = '0, cond_i = 4'hE;
    logic        set_flags_i = 1'b0, shift_carry_i = 1'b0;
    logic [31:0] opnd_a_i = '0, opnd_b_i = '0;
    logic [31:0] alu_res_o;
    logic        dst_we_o;
    logic [3:0]  flags_nxt_o;

    int checks = 0, errors = 0;
    logic [3:0] mflags = 4'b0000;  // model of held flags {N,Z,C,V}
    bit done = 0;

    always #2 clk = ~clk;  // 250 MHz

    cc_alu u0 (.*);

    function automatic bit cond_ok(input logic [3:0] cc, input logic [3:0] f);
        bit n = f[3], z = f[2], c = f[1], v = f[0];
        case (cc)
            4'h0: return z;          4'h1: return !z;
            4'h2: return c;          4'h3: return !c;
            4'h4: return n;          4'h5: return !n;
            4'h6: return v;          4'h7: return !v;
            4'h8: return c && !z;    4'h9: return !c || z;
            4'hA: return n == v;     4'hB: return n != v;
            4'hC: return !z && n == v; 4'hD: return z || n != v;
            4'hE: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    // Reference: result, write enable and next flags from the requirements.
    task automatic model(input logic [3:0] op, cc, input bit sf, input logic [31:0] a, b,
                         input bit shc, output logic [31:0] res, output bit we,
                         output logic [3:0] nf, output string tag);
        longint ua = longint'({32'b0, a}), ub = longint'({32'b0, b});
        longint sa = longint'($signed(a)), sb = longint'($signed(b));
        longint ci = longint'(mflags[1]);
        longint ut = 0, st = 0;
        bit arith = 1, fonly, ex, c_new, v_new;
        case (op)
            4'h4, 4'hB: begin ut = ua + ub;          st = sa + sb;          end
            4'h5:       begin ut = ua + ub + ci;     st = sa + sb + ci;     end
            4'h2, 4'hA: begin ut = ua - ub;          st = sa - sb;          end
            4'h6:       begin ut = ua - ub + ci - 1; st = sa - sb + ci - 1; end
            4'h3:       begin ut = ub - ua;          st = sb - sa;          end
            4'h7:       begin ut = ub - ua + ci - 1; st = sb - sa + ci - 1; end
            default: arith = 0;
        endcase
        if (arith) begin
            res = ut[31:0];
            if (op inside {4'h4, 4'h5, 4'hB}) c_new = (ut > 64'sh0FFFFFFFF);
            else c_new = (ut >= 0);
            v_new = (st > 64'sh7FFFFFFF) || (st < -64'sh80000000);
            tag = "R1";
        end else begin
            case (op)
                4'h0, 4'h8: res = a & b;
                4'h1, 4'h9: res = a ^ b;
                4'hC: res = a | b;
                4'hE: res = a & ~b;
                4'hD: res = b;
                default: res = ~b;
            endcase
            c_new = shc; v_new = mflags[0];
            tag = "R2";
        end
        fonly = (op inside {4'h8, 4'h9, 4'hA, 4'hB});
        if (fonly) tag = "R3";
        ex = cond_ok(cc, mflags);
        we = ex && !fonly;
        if (ex && (fonly || sf)) nf = {res[31], res == 32'h0, c_new, v_new};
        else nf = mflags;
    endtask

    task automatic check(input bit ok, input string tag, input logic [63:0] act, exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Drive one operation on the falling edge, check, then commit at the rising edge.
    task automatic run(input logic [3:0] op, cc, input bit sf, input logic [31:0] a, b,
                       input bit shc, input string tag_in);
        logic [31:0] er; bit ew; logic [3:0] ef; string tg;
        @(negedge clk);
        opcode_i = op; cond_i = cc; set_flags_i = sf;
        opnd_a_i = a; opnd_b_i = b; shift_carry_i = shc;
        model(op, cc, sf, a, b, shc, er, ew, ef, tg);
        if (tag_in != "") tg = tag_in;
        #1;
        check(dst_we_o == ew, {tg, " we"}, 64'(dst_we_o), 64'(ew));
        check(flags_nxt_o == ef, {tg, " flags"}, 64'(flags_nxt_o), 64'(ef));
        if (ew) check(alu_res_o == er, {tg, " result"}, 64'(alu_res_o), 64'(er));
        @(posedge clk);
        mflags = ef;
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        // R11: reset state visible through a non-updating move
        run(4'hD, 4'hE, 0, 32'h0, 32'h5, 0, "R11");
        check(flags_nxt_o == 4'b0000, "R11 reset flags", 64'(flags_nxt_o), 64'h0);
        // R8 / R5: signed overflow on add
        run(4'h4, 4'hE, 1, 32'h7FFFFFFF, 32'h1, 0, "R8");
        // R6: borrow on subtract gives C=0
        run(4'h2, 4'hE, 1, 32'h0, 32'h1, 0, "R6");
        // R6 / R5: equal compare gives Z=1, C=1
        run(4'hA, 4'hE, 0, 32'h1234, 32'h1234, 0, "R6");
        // R1: carry-in forms with C=1
        run(4'h5, 4'hE, 0, 32'hFFFFFFFF, 32'h0, 0, "R1");
        run(4'h6, 4'hE, 0, 32'h10, 32'h3, 0, "R1");
        run(4'h7, 4'hE, 1, 32'h3, 32'h10, 0, "R1");
        // R7: logical update takes shifter carry and keeps V
        run(4'h4, 4'hE, 1, 32'h80000000, 32'h80000000, 0, "R8");
        run(4'hE, 4'hE, 1, 32'hFF00FF00, 32'h0F0F0F0F, 1, "R7");
        run(4'h8, 4'hE, 0, 32'h0, 32'hFFFFFFFF, 0, "R7");
        // R4: set-flags 0 keeps flags
        run(4'h3, 4'hE, 0, 32'h5, 32'h2, 1, "R4");
        // R9: every condition against several flag states
        for (int s = 0; s < 4; s++) begin
            case (s)
                0: run(4'hA, 4'hE, 0, 32'h5, 32'h5, 0, "R9");
                1: run(4'hA, 4'hE, 0, 32'h1, 32'h2, 0, "R9");
                2: run(4'hA, 4'hE, 0, 32'h80000000, 32'h1, 0, "R9");
                default: run(4'hA, 4'hE, 0, 32'h9, 32'h2, 0, "R9");
            endcase
            for (int cc = 0; cc < 16; cc++)
                run(4'hD, 4'(cc), 0, 32'h0, 32'hA5A5, 0, cc == 15 ? "R10" : "R9");
        end
        // R10: failed condition with set-flags and a flag-only op
        run(4'hA, 4'hE, 0, 32'h5, 32'h5, 0, "R9");
        run(4'h4, 4'h1, 1, 32'h1, 32'h1, 1, "R10");
        run(4'hB, 4'hF, 0, 32'h7FFFFFFF, 32'h7FFFFFFF, 1, "R10");
        // Random mix
        for (int i = 0; i < 4000; i++) begin
            logic [31:0] a = $urandom(), b = $urandom();
            int sel = $urandom_range(0, 9);
            if (sel == 0) a = 32'h0;
            if (sel == 1) b = a;
            if (sel == 2) a = 32'h7FFFFFFF;
            if (sel == 3) b = 32'h80000000;
            run(4'($urandom()), ($urandom_range(0, 3) == 0) ? 4'($urandom()) : 4'hE,
                1'($urandom()), a, b, 1'($urandom()), "");
        end
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                errors++; checks++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule